// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register slave of a simple byte-oriented serial port. A processor reaches it through a single-cycle bus with word-aligned offsets. Received bytes arrive on a byte-wide valid/ready stream and are stored in a circular FIFO of 32-bit entries. The processor pops that FIFO by reading the data register. Bytes the processor writes to the data register are presented at once on a byte-wide transmit stream. A single level-sensitive interrupt combines three enabled sources.

Direct-memory transfers are carried out by engines outside this block. For transmit, the block holds the source pointer and hands a start pulse with address and length to the transmit engine. For receive, the block holds the destination pointer and the remaining byte count. It moves bytes to the receive engine through a write port: first it drains the bytes already waiting in the FIFO, one per cycle, and then it forwards incoming bytes directly until the count reaches zero.

Top module: `serport_csr`

## Requirements
- R1: The register index is address bits [11:2]; higher address bits and bits [1:0] have no effect. Index 0 reads the parameter ID_VALUE, 1 is data, 2 reads the FIFO occupancy, 3 is interrupt enable (bits [2:0]), 4 is the transmit pointer, 5 is the transmit length (reads 0), 6 is the receive pointer, 7 reads the remaining receive count, and 8 reads the FIFO depth.
- R2: Reading index 1 while the FIFO holds entries returns the oldest entry (received byte in bits [7:0], zeros above) and removes it. Reading index 1 while the FIFO is empty returns 0xFFFFFFFF and changes nothing.
- R3: The FIFO keeps first-in first-out order across wraparound of its circular storage, and holds at most the depth. With the FIFO full and no receive count pending, rx_ready is low, so no byte is lost or stored.
- R4: A write to index 1 places bits [7:0] of the written value on tx_data and raises tx_valid in the next cycle. tx_valid and tx_data stay unchanged until a cycle with tx_ready high, after which tx_valid drops.
- R5: irq is high when any of these holds: enable bit 0 is set and the FIFO is not empty; enable bit 1 is set (no further condition); enable bit 2 is set, the remaining receive count is zero and no FIFO drain is in progress.
- R6: Writing a value V to index 7 drains min(V, occupancy) FIFO entries to the receive write port, one per cycle starting in the next cycle, at consecutive addresses starting at the receive pointer. The remaining count becomes V minus the occupancy when V is larger, and zero otherwise.
- R7: A byte received while the remaining count is nonzero goes out on the receive write port at the receive pointer. It does not enter the FIFO. The pointer then increments and the count decrements.
- R8: rx_credit equals the remaining receive count when that is nonzero and otherwise the number of free FIFO slots. rx_credit is zero while a drain is in progress. rx_ready is high when rx_credit is nonzero and the bus is not writing index 6 or 7.
- R9: Writing index 6 loads the receive pointer and clears both the remaining count and any drain in progress. Entries not yet drained stay in the FIFO.
- R10: Writing a nonzero value L to index 5 gives a one-cycle dma_tx_go pulse in the next cycle, with dma_tx_addr equal to the old transmit pointer and dma_tx_len equal to L. The pointer then advances by L. Writing zero gives no pulse.
- R11: FIFO_DEPTH defaults to 16, and a value of zero or less is replaced by 16.
- R12: A received byte and a data-register pop in the same cycle both take effect: the occupancy is unchanged, and the order is kept.
- R13: While a drain is in progress, reading index 1 returns 0xFFFFFFFF and removes nothing.
- R14: Writes to indexes 0, 2 and 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit sink accepts |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block accepts a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_credit | output | 32 | Bytes the block can take now |
| dma_tx_go | output | 1 | Transmit transfer start pulse |
| dma_tx_addr | output | 32 | Transmit transfer source address |
| dma_tx_len | output | 32 | Transmit transfer length |
| dma_rx_wvalid | output | 1 | Receive write port valid |
| dma_rx_waddr | output | 32 | Receive write address |
| dma_rx_wdata | output | 8 | Receive write byte |

## Verification
Two FIFO operations can fall in the same cycle: a receive push and a data-register pop. The bench lowers the occupancy below full, then asserts rx_valid in the same cycle as a read of the data register. It checks that the read returns the old head, that the occupancy afterwards is unchanged, and that later reads return the rest in order, with the new byte last. A second overlap is a drain running while the bus reads the data register. The bench issues that read in the first drain cycle and judges it by the all-ones return, the unchanged sequence of write-port addresses and bytes, and rx_ready being low throughout.

// File: rtl/serport_pkg.sv
package serport_pkg;

    typedef enum logic [9:0] {
        REG_ID    = 10'd0,
        REG_DATA  = 10'd1,
        REG_COUNT = 10'd2,
        REG_IRQEN = 10'd3,
        REG_TXPTR = 10'd4,
        REG_TXLEN = 10'd5,
        REG_RXPTR = 10'd6,
        REG_RXLEN = 10'd7,
        REG_DEPTH = 10'd8
    } reg_idx_e;

    localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;
    localparam int IRQ_FIFO_BIT = 0;
    localparam int IRQ_TX_BIT   = 1;
    localparam int IRQ_RX_BIT   = 2;
    localparam int IRQ_BITS     = 3;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic wr_irqen;
        logic wr_txptr;
        logic wr_txlen;
        logic wr_rxptr;
        logic wr_rxlen;
    } strobe_t;

    function automatic int fix_depth(input int d);
        return (d <= 0) ? 16 : d;
    endfunction

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_pos;
    logic [CNT_W:0]   wsum;
    logic [PTR_W-1:0] wslot;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_pos];

    // slot = (read position + occupancy) modulo depth
    always_comb begin
        wsum = (CNT_W+1)'(rd_pos) + (CNT_W+1)'(count);
        if (wsum >= (CNT_W+1)'(DEPTH)) begin
            wsum = wsum - (CNT_W+1)'(DEPTH);
        end
        wslot = PTR_W'(wsum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pos <= '0;
            count  <= '0;
        end else begin
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
            if (do_pop) begin
                rd_pos <= (rd_pos == PTR_W'(DEPTH - 1)) ? '0 : rd_pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wslot] <= push_data;
        end
    end

endmodule

// File: rtl/serport_rxdma.sv
module serport_rxdma #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ptr,
    input  logic             wr_len,
    input  logic [31:0]      wdata,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             rx_to_dma,
    output logic [31:0]      ptr,
    output logic [31:0]      rem,
    output logic             busy,
    output logic             drain_pop
);

    logic [CNT_W-1:0] drain_left;

    assign busy      = (drain_left != '0);
    assign drain_pop = busy && !wr_ptr && !wr_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            rem        <= '0;
            drain_left <= '0;
        end else if (wr_ptr) begin
            ptr        <= wdata;
            rem        <= '0;
            drain_left <= '0;
        end else if (wr_len) begin
            if (wdata > 32'(fifo_count)) begin
                rem        <= wdata - 32'(fifo_count);
                drain_left <= fifo_count;
            end else begin
                rem        <= '0;
                drain_left <= CNT_W'(wdata);
            end
        end else if (busy) begin
            ptr        <= ptr + 32'd1;
            drain_left <= drain_left - 1'b1;
        end else if (rx_to_dma) begin
            ptr <= ptr + 32'd1;
            rem <= rem - 32'd1;
        end
    end

endmodule

// File: rtl/serport_tx.sv
module serport_tx (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_byte,
    input  logic        wr_ptr,
    input  logic        wr_len,
    input  logic [31:0] wdata,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic [31:0] ptr,
    output logic        go,
    output logic [31:0] go_addr,
    output logic [31:0] go_len
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (wr_byte) begin
            tx_valid <= 1'b1;
            tx_data  <= wdata[7:0];
        end else if (tx_valid && tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            go      <= 1'b0;
            go_addr <= '0;
            go_len  <= '0;
        end else begin
            go <= 1'b0;
            if (wr_ptr) begin
                ptr <= wdata;
            end else if (wr_len && (wdata != '0)) begin
                go      <= 1'b1;
                go_addr <= ptr;
                go_len  <= wdata;
                ptr     <= ptr + wdata;
            end
        end
    end

endmodule

// File: rtl/serport_csr.sv
module serport_csr
    import serport_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          FIFO_DEPTH = 16,
    parameter logic [31:0] ID_VALUE   = 32'h5350_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    output logic [31:0]       rx_credit,
    output logic              dma_tx_go,
    output logic [31:0]       dma_tx_addr,
    output logic [31:0]       dma_tx_len,
    output logic              dma_rx_wvalid,
    output logic [31:0]       dma_rx_waddr,
    output logic [7:0]        dma_rx_wdata
);

    localparam int DEPTH_EFF = fix_depth(FIFO_DEPTH);
    localparam int CNT_W     = $clog2(DEPTH_EFF + 1);

    logic [9:0]          reg_idx;
    logic                addr_unused;
    strobe_t             stb;
    logic [IRQ_BITS-1:0] irq_en;
    logic [CNT_W-1:0]    fifo_count;
    logic [31:0]         fifo_head;
    logic                fifo_pop;
    logic                fifo_push;
    logic [31:0]         rx_ptr;
    logic [31:0]         rx_rem;
    logic                rx_busy;
    logic                drain_pop;
    logic                rx_fire;
    logic                rx_to_dma;
    logic [31:0]         tx_ptr;

    assign reg_idx     = bus_addr[11:2];
    assign addr_unused = ^{bus_addr[ADDR_W-1:12], bus_addr[1:0]};

    always_comb begin
        stb          = '0;
        stb.rd_data  = bus_sel && !bus_wr && (reg_idx == REG_DATA);
        stb.wr_data  = bus_sel && bus_wr && (reg_idx == REG_DATA);
        stb.wr_irqen = bus_sel && bus_wr && (reg_idx == REG_IRQEN);
        stb.wr_txptr = bus_sel && bus_wr && (reg_idx == REG_TXPTR);
        stb.wr_txlen = bus_sel && bus_wr && (reg_idx == REG_TXLEN);
        stb.wr_rxptr = bus_sel && bus_wr && (reg_idx == REG_RXPTR);
        stb.wr_rxlen = bus_sel && bus_wr && (reg_idx == REG_RXLEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en <= '0;
        end else if (stb.wr_irqen) begin
            irq_en <= bus_wdata[IRQ_BITS-1:0];
        end
    end

    // receive side: credit, ready and routing between FIFO and write port
    always_comb begin
        if (rx_busy) begin
            rx_credit = '0;
        end else if (rx_rem != '0) begin
            rx_credit = rx_rem;
        end else begin
            rx_credit = 32'(DEPTH_EFF) - 32'(fifo_count);
        end
    end

    assign rx_ready  = (rx_credit != '0) && !stb.wr_rxptr && !stb.wr_rxlen;
    assign rx_fire   = rx_valid && rx_ready;
    assign rx_to_dma = rx_fire && (rx_rem != '0);
    assign fifo_push = rx_fire && (rx_rem == '0);
    assign fifo_pop  = drain_pop || (stb.rd_data && !rx_busy);

    serport_fifo #(.DEPTH(DEPTH_EFF), .WIDTH(32)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_data ({24'h0, rx_data}),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_count)
    );

    serport_rxdma #(.CNT_W(CNT_W)) u_rxdma (
        .clk        (clk),
        .rst        (rst),
        .wr_ptr     (stb.wr_rxptr),
        .wr_len     (stb.wr_rxlen),
        .wdata      (bus_wdata),
        .fifo_count (fifo_count),
        .rx_to_dma  (rx_to_dma),
        .ptr        (rx_ptr),
        .rem        (rx_rem),
        .busy       (rx_busy),
        .drain_pop  (drain_pop)
    );

    assign dma_rx_wvalid = drain_pop || rx_to_dma;
    assign dma_rx_waddr  = rx_ptr;
    assign dma_rx_wdata  = drain_pop ? fifo_head[7:0] : rx_data;

    serport_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .wr_byte  (stb.wr_data),
        .wr_ptr   (stb.wr_txptr),
        .wr_len   (stb.wr_txlen),
        .wdata    (bus_wdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .ptr      (tx_ptr),
        .go       (dma_tx_go),
        .go_addr  (dma_tx_addr),
        .go_len   (dma_tx_len)
    );

    assign irq = (irq_en[IRQ_FIFO_BIT] && (fifo_count != '0))
              || irq_en[IRQ_TX_BIT]
              || (irq_en[IRQ_RX_BIT] && (rx_rem == '0) && !rx_busy);

    always_comb begin
        case (reg_idx)
            REG_ID:    bus_rdata = ID_VALUE;
            REG_DATA:  bus_rdata = (rx_busy || (fifo_count == '0)) ? EMPTY_WORD : fifo_head;
            REG_COUNT: bus_rdata = 32'(fifo_count);
            REG_IRQEN: bus_rdata = 32'(irq_en);
            REG_TXPTR: bus_rdata = tx_ptr;
            REG_TXLEN: bus_rdata = '0;
            REG_RXPTR: bus_rdata = rx_ptr;
            REG_RXLEN: bus_rdata = rx_rem;
            REG_DEPTH: bus_rdata = 32'(DEPTH_EFF);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/serport_csr_chk.sv
module serport_csr_chk
    import serport_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic                clk,
    input logic                rst,
    input logic [CNT_W-1:0]    fifo_count,
    input logic [31:0]         rx_rem,
    input logic                busy,
    input logic                rx_ready,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic [7:0]          tx_data,
    input strobe_t             stb,
    input logic [31:0]         wdata,
    input logic                irq,
    input logic [IRQ_BITS-1:0] irq_en,
    input logic                dma_tx_go,
    input logic [31:0]         dma_tx_len
);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH));

    p_full_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        ((fifo_count == CNT_W'(DEPTH)) && (rx_rem == '0)) |-> !rx_ready);

    p_drain_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rx_ready);

    p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !stb.wr_data) |=> (tx_valid && $stable(tx_data)));

    p_tx_source_r5: assert property (@(posedge clk) disable iff (rst)
        irq_en[IRQ_TX_BIT] |-> irq);

    p_go_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (stb.wr_txlen && (wdata != '0)) |=> (dma_tx_go && (dma_tx_len == $past(wdata))));

    p_go_only_r10: assert property (@(posedge clk) disable iff (rst)
        !(stb.wr_txlen && (wdata != '0)) |=> !dma_tx_go);

endmodule

bind serport_csr serport_csr_chk #(.DEPTH(DEPTH_EFF), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_count (fifo_count),
    .rx_rem     (rx_rem),
    .busy       (rx_busy),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .stb        (stb),
    .wdata      (bus_wdata),
    .irq        (irq),
    .irq_en     (irq_en),
    .dma_tx_go  (dma_tx_go),
    .dma_tx_len (dma_tx_len)
);

// File: tb/serport_csr_tb.sv
`timescale 1ns/1ps
module serport_csr_tb;

    localparam logic [31:0] ID = 32'h5350_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] rdata, zrdata;
    logic        irq, tx_valid, rx_ready, dma_tx_go, dma_rx_wvalid;
    logic        tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_data, dma_rx_wdata;
    logic [7:0]  rx_data = '0;
    logic [31:0] rx_credit, dma_tx_addr, dma_tx_len, dma_rx_waddr;

    logic        z_irq, z_txv, z_rxr, z_go, z_wv;
    logic [7:0]  z_txd, z_wd;
    logic [31:0] z_cr, z_ga, z_gl, z_wa;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0]  fifo_q[$];
    logic [39:0] exp_dma[$];
    logic [7:0]  exp_tx[$];
    logic [31:0] m_ptr = '0;
    logic [31:0] m_rem = '0;

    always #4 clk = ~clk;

    serport_csr u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq(irq), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_credit(rx_credit), .dma_tx_go(dma_tx_go),
        .dma_tx_addr(dma_tx_addr), .dma_tx_len(dma_tx_len), .dma_rx_wvalid(dma_rx_wvalid),
        .dma_rx_waddr(dma_rx_waddr), .dma_rx_wdata(dma_rx_wdata)
    );

    serport_csr #(.FIFO_DEPTH(0)) u_dut_zero (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(zrdata), .irq(z_irq), .tx_valid(z_txv),
        .tx_ready(1'b1), .tx_data(z_txd), .rx_valid(1'b0), .rx_ready(z_rxr),
        .rx_data(8'h00), .rx_credit(z_cr), .dma_tx_go(z_go),
        .dma_tx_addr(z_ga), .dma_tx_len(z_gl), .dma_rx_wvalid(z_wv),
        .dma_rx_waddr(z_wa), .dma_rx_wdata(z_wd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] idx(input int i);
        return 32'(i) << 2;
    endfunction

    task automatic bus_write(input int i, input logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = idx(i); bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] v, output logic [31:0] zv);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        v = rdata; zv = zrdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(input string tag, input int i, input logic [31:0] exp);
        logic [31:0] v, zv;
        bus_read(idx(i), v, zv);
        chk(tag, v, exp);
    endtask

    task automatic pop_chk(input string tag);
        logic [31:0] v, zv, e;
        e = (fifo_q.size() > 0) ? {24'h0, fifo_q.pop_front()} : 32'hFFFF_FFFF;
        bus_read(idx(1), v, zv);
        chk(tag, v, e);
    endtask

    // driver: offers one receive byte and records where it must land
    task automatic rx_put(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        #1;
        while (!rx_ready) begin
            @(posedge clk); #2;
        end
        if (m_rem != '0) begin
            exp_dma.push_back({m_ptr, b});
            m_ptr++; m_rem--;
        end else begin
            fifo_q.push_back(b);
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    // monitor: compares write-port and transmit traffic with the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (dma_rx_wvalid) begin
                if (exp_dma.size() == 0) begin
                    chk("R6 R7 unexpected write-port beat", {24'h0, dma_rx_wdata}, 32'hDEAD);
                end else begin
                    logic [39:0] e;
                    e = exp_dma.pop_front();
                    chk("R6 R7 write-port address", dma_rx_waddr, e[39:8]);
                    chk("R6 R7 write-port byte", {24'h0, dma_rx_wdata}, {24'h0, e[7:0]});
                end
            end
            if (tx_valid && tx_ready) begin
                if (exp_tx.size() == 0) begin
                    chk("R4 unexpected transmit byte", {24'h0, tx_data}, 32'hDEAD);
                end else begin
                    chk("R4 transmit byte", {24'h0, tx_data}, {24'h0, exp_tx.pop_front()});
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, zv;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        chk("R8 reset credit", rx_credit, 32'd16);
        chk("R5 reset irq", {31'h0, irq}, 32'h0);
        chk("R4 reset tx_valid", {31'h0, tx_valid}, 32'h0);
        read_chk("R1 id", 0, ID);
        bus_read(idx(8), v, zv);
        chk("R11 default depth", v, 32'd16);
        chk("R11 zero depth forced", zv, 32'd16);
        read_chk("R1 tx length reads zero", 5, 32'h0);
        read_chk("R3 reset count", 2, 32'h0);
        read_chk("R1 irq enable reset", 3, 32'h0);

        // empty pop
        pop_chk("R2 empty read");
        read_chk("R2 empty read leaves count", 2, 32'h0);

        // simple receive and ordered pops, high address bits ignored
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33);
        read_chk("R3 count after three", 2, 32'd3);
        chk("R8 credit free slots", rx_credit, 32'd13);
        bus_read(32'hABCD_F004, v, zv);
        chk("R1 upper bits ignored", v, {24'h0, fifo_q.pop_front()});

        // interrupt sources
        bus_write(3, 32'h1);
        chk("R5 fifo source", {31'h0, irq}, 32'h1);
        read_chk("R1 irq enable readback", 3, 32'h1);
        pop_chk("R2 pop second");
        pop_chk("R2 pop third");
        chk("R5 fifo source empty", {31'h0, irq}, 32'h0);
        bus_write(3, 32'h2);
        chk("R5 transmit source", {31'h0, irq}, 32'h1);
        bus_write(3, 32'h4);
        chk("R5 receive-complete source", {31'h0, irq}, 32'h1);
        bus_write(3, 32'h0);

        // fill, hold off, simultaneous push and pop, wraparound
        for (int i = 0; i < 16; i++) rx_put(8'h40 + 8'(i));
        read_chk("R3 full count", 2, 32'd16);
        chk("R3 full rx_ready", {31'h0, rx_ready}, 32'h0);
        chk("R8 full credit", rx_credit, 32'h0);
        rx_valid = 1'b1; rx_data = 8'hEE;
        repeat (3) begin @(posedge clk); #1; end
        chk("R3 held off while full", {31'h0, rx_ready}, 32'h0);
        rx_valid = 1'b0;
        read_chk("R3 no overflow", 2, 32'd16);
        pop_chk("R3 pop oldest");
        rx_valid = 1'b1; rx_data = 8'h77;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = idx(1);
        #2;
        chk("R12 ready during pop", {31'h0, rx_ready}, 32'h1);
        chk("R12 pop returns old head", rdata, {24'h0, fifo_q.pop_front()});
        fifo_q.push_back(8'h77);
        @(posedge clk); #1;
        rx_valid = 1'b0; bus_sel = 1'b0;
        read_chk("R12 count unchanged", 2, 32'd15);
        for (int i = 0; i < 15; i++) pop_chk("R3 wraparound order");
        read_chk("R3 empty after wrap", 2, 32'h0);

        // transmit byte path
        tx_ready = 1'b0;
        exp_tx.push_back(8'hA5);
        bus_write(1, 32'h0000_01A5);
        chk("R4 tx_valid raised", {31'h0, tx_valid}, 32'h1);
        chk("R4 tx_data low byte", {24'h0, tx_data}, 32'hA5);
        repeat (2) begin @(posedge clk); #1; end
        chk("R4 held valid", {31'h0, tx_valid}, 32'h1);
        chk("R4 held data", {24'h0, tx_data}, 32'hA5);
        tx_ready = 1'b1;
        @(posedge clk); #1;
        chk("R4 dropped after accept", {31'h0, tx_valid}, 32'h0);
        exp_tx.push_back(8'h3C);
        bus_write(1, 32'h3C);
        @(posedge clk); #1;

        // transmit transfer start
        bus_write(4, 32'h1000);
        bus_write(5, 32'h20);
        chk("R10 go pulse", {31'h0, dma_tx_go}, 32'h1);
        chk("R10 go address", dma_tx_addr, 32'h1000);
        chk("R10 go length", dma_tx_len, 32'h20);
        @(posedge clk); #1;
        chk("R10 single cycle", {31'h0, dma_tx_go}, 32'h0);
        read_chk("R10 pointer advanced", 4, 32'h1020);
        bus_write(5, 32'h0);
        chk("R10 zero length no pulse", {31'h0, dma_tx_go}, 32'h0);

        // receive transfer: drain then direct forwarding
        rx_put(8'hA1); rx_put(8'hA2); rx_put(8'hA3);
        bus_write(6, 32'h2000);
        m_ptr = 32'h2000; m_rem = 32'h0;
        for (int i = 0; i < 3; i++) begin
            exp_dma.push_back({m_ptr, fifo_q.pop_front()});
            m_ptr++;
        end
        m_rem = 32'd2;
        bus_write(7, 32'd5);
        chk("R8 drain blocks ready", {31'h0, rx_ready}, 32'h0);
        chk("R8 drain credit zero", rx_credit, 32'h0);
        bus_read(idx(1), v, zv);
        chk("R13 read during drain", v, 32'hFFFF_FFFF);
        repeat (2) begin @(posedge clk); #1; end
        chk("R6 drain complete", 32'(exp_dma.size()), 32'h0);
        chk("R8 credit is remaining count", rx_credit, 32'd2);
        read_chk("R6 remaining count", 7, 32'd2);
        read_chk("R6 fifo emptied", 2, 32'h0);
        bus_write(3, 32'h4);
        chk("R5 receive pending", {31'h0, irq}, 32'h0);
        rx_put(8'hB1); rx_put(8'hB2);
        read_chk("R7 bypasses fifo", 2, 32'h0);
        chk("R5 receive complete", {31'h0, irq}, 32'h1);
        read_chk("R7 pointer advanced", 6, 32'h2005);
        bus_write(3, 32'h0);

        bus_write(7, 32'd4);
        m_rem = 32'd4;
        chk("R8 credit from count", rx_credit, 32'd4);
        bus_write(6, 32'h3000);
        m_ptr = 32'h3000; m_rem = 32'h0;
        read_chk("R9 count cleared", 7, 32'h0);
        read_chk("R9 pointer loaded", 6, 32'h3000);
        chk("R9 credit back to slots", rx_credit, 32'd16);

        rx_put(8'hC1); rx_put(8'hC2);
        bus_write(7, 32'd2);
        bus_write(6, 32'h4000);
        m_ptr = 32'h4000;
        read_chk("R9 cancelled drain keeps entries", 2, 32'd2);
        pop_chk("R9 kept first");
        pop_chk("R9 kept second");

        // read-only registers
        bus_write(8, 32'd5);
        bus_write(0, 32'd9);
        bus_write(2, 32'd7);
        read_chk("R14 depth unchanged", 8, 32'd16);
        read_chk("R14 id unchanged", 0, ID);
        read_chk("R14 count unchanged", 2, 32'h0);

        repeat (2) begin @(posedge clk); #1; end
        chk("R6 R7 no missing writes", 32'(exp_dma.size()), 32'h0);
        chk("R4 no missing bytes", 32'(exp_tx.size()), 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule